// File: doc/BRIEF.md
# Peripheral Interrupt Priority Router

This block sits between a set of peripheral interrupt request lines (64 by default) and the seven prioritised interrupt inputs of a processor core, numbered 7 to 13. Software gives every peripheral a 4-bit routing field. A field value k sends that peripheral to core level 7+k. For each level the block drives a request output, which is the OR of all requests that are pending, unmasked and routed to that level. Next to each request output it drives the index of the lowest-numbered peripheral that is active on that level.

The core asks which peripheral to service through a one-cycle claim: it gives a level number, and one clock later the block returns that level's winner. If nothing is active on the claimed level, the block reports a miss and advances a spurious-event counter that software can read. A separate set of wakeup-enable bits drives one wake output. The wake output looks at raw requests and ignores the masks, so a device can rouse a sleeping core without having its interrupt unmasked.

Registers are reached over a simple word-addressed bus. Writes take effect on a clock edge. Reads are combinational.

Top module: `irq_router`

## Requirements
- R1: After reset every routing field reads 0, every mask bit reads 0 (all sources masked), the spurious counter reads 0, and every output is 0. With all sources masked, requests on the inputs raise no level output.
- R2: The register map is word-addressed and, with 64 sources, is laid out as follows:
  - addresses 0 to 7: routing registers;
  - 8 and 9: mask banks;
  - 10 and 11: status banks;
  - 12 and 13: wakeup-enable banks;
  - 14: spurious counter.

  Routing, mask and wakeup registers read back the value written. A status bank reads the live request inputs, with source n at bank n/32, bit n%32.
- R3: Source n uses bits [(n%8)*4+3:(n%8)*4] of routing register n/8. A field value k from 0 to 6 routes the source to level output bit k (core level 7+k). The output `lvl_vec_o` holds level k's winner index in bits [k*6+5:k*6].
- R4: A source whose routing field holds 7 to 15 drives no level output.
- R5: A source is active on its level only when its request input is 1 and its mask bit is 1 (mask bank n/32, bit n%32). Clearing the mask bit removes the source from its level.
- R6: When several sources are active on one level, the reported index is the lowest-numbered active source.
- R7: Level outputs and level vectors are registered. A change on the request inputs appears one clock edge later and not before.
- R8: A claim (`claim_valid_i` with level k in 0..6) gives, one edge later, `claim_done_o`=1. With it comes `claim_hit_o`=1 and `claim_vec_o` equal to that level's current winner when one exists.
- R9: A claim on a level with no active source, or on a level number of 7, gives `claim_hit_o`=0 and `claim_vec_o`=0, and adds one to the spurious counter.
- R10: Wakeup-enable bits use the same bank and bit layout as the masks. `wake_o` becomes 1 one edge after any source with its wakeup bit set has its request high, whatever its mask bit, and 0 otherwise.
- R11: Writes to the status banks and to the spurious counter are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W (5) | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_i | input | NUM_SRC (64) | Level-sensitive peripheral requests |
| claim_valid_i | input | 1 | Claim strobe from the core |
| claim_lvl_i | input | 3 | Claimed level, 0 means core level 7 |
| lvl_irq_o | output | 7 | Per-level request to the core |
| lvl_vec_o | output | 7*IDX_W (42) | Per-level winner indices, level k at [k*IDX_W +: IDX_W] |
| wake_o | output | 1 | Wake request |
| claim_done_o | output | 1 | Claim answer valid |
| claim_hit_o | output | 1 | Claim found an active source |
| claim_vec_o | output | IDX_W (6) | Winning source of the claim |

## Verification
Two sources are routed to different levels, one in each mask bank, to show that field packing, bank layout and level numbering separate correctly. Routing values above 6 and cleared masks are then applied, so that a source that drives a level can be told apart from one that must stay silent. Three sources sharing one level are removed one at a time, lowest first, which shows the lowest-index priority rule at each step. Claims on an occupied level, an empty level and the out-of-range level 7 separate a hit from a spurious count. The wake tests use masked sources, so that wake is seen to follow the enables and not the masks.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
    localparam int LVL_COUNT      = 7;
    localparam int FIELD_W        = 4;
    localparam int FIELDS_PER_REG = 8;
    localparam int BANK_W         = 32;
    localparam int LVL_SEL_W      = 3;
endpackage

// File: rtl/irq_router_cfg.sv
`timescale 1ns/1ps
module irq_router_cfg
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 5,
    parameter int CNT_W   = 16
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        bus_we_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic [BANK_W-1:0]           bus_wdata_i,
    input  logic [NUM_SRC-1:0]          raw_irq_i,
    input  logic [CNT_W-1:0]            spur_cnt_i,
    output logic [NUM_SRC*FIELD_W-1:0]  fld_o,
    output logic [NUM_SRC-1:0]          msk_o,
    output logic [NUM_SRC-1:0]          wen_o,
    output logic [BANK_W-1:0]           bus_rdata_o
);
    localparam int N_ASG    = NUM_SRC / FIELDS_PER_REG;
    localparam int N_BANK   = NUM_SRC / BANK_W;
    localparam int MSK_BASE = N_ASG;
    localparam int STA_BASE = MSK_BASE + N_BANK;
    localparam int WEN_BASE = STA_BASE + N_BANK;
    localparam int CNT_ADDR = WEN_BASE + N_BANK;

    typedef struct packed {
        logic [NUM_SRC*FIELD_W-1:0] fld;
        logic [NUM_SRC-1:0]         msk;
        logic [NUM_SRC-1:0]         wen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // next-state: decode writes; status and counter addresses have no storage
    always_comb begin
        cfg_d = cfg_q;
        if (bus_we_i) begin
            for (int r = 0; r < N_ASG; r++) begin
                if (bus_addr_i == ADDR_W'(r))
                    cfg_d.fld[r*BANK_W +: BANK_W] = bus_wdata_i;
            end
            for (int b = 0; b < N_BANK; b++) begin
                if (bus_addr_i == ADDR_W'(MSK_BASE + b))
                    cfg_d.msk[b*BANK_W +: BANK_W] = bus_wdata_i;
                if (bus_addr_i == ADDR_W'(WEN_BASE + b))
                    cfg_d.wen[b*BANK_W +: BANK_W] = bus_wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    // read multiplexer
    always_comb begin
        bus_rdata_o = '0;
        for (int r = 0; r < N_ASG; r++) begin
            if (bus_addr_i == ADDR_W'(r))
                bus_rdata_o = cfg_q.fld[r*BANK_W +: BANK_W];
        end
        for (int b = 0; b < N_BANK; b++) begin
            if (bus_addr_i == ADDR_W'(MSK_BASE + b))
                bus_rdata_o = cfg_q.msk[b*BANK_W +: BANK_W];
            if (bus_addr_i == ADDR_W'(STA_BASE + b))
                bus_rdata_o = raw_irq_i[b*BANK_W +: BANK_W];
            if (bus_addr_i == ADDR_W'(WEN_BASE + b))
                bus_rdata_o = cfg_q.wen[b*BANK_W +: BANK_W];
        end
        if (bus_addr_i == ADDR_W'(CNT_ADDR))
            bus_rdata_o = BANK_W'(spur_cnt_i);
    end

    assign fld_o = cfg_q.fld;
    assign msk_o = cfg_q.msk;
    assign wen_o = cfg_q.wen;
endmodule

// File: rtl/irq_router_sel.sv
`timescale 1ns/1ps
module irq_router_sel #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_SRC-1:0] cand_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    // lowest set index wins: scan downward so the last hit is the smallest
    always_comb begin
        any_o = |cand_i;
        idx_o = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (cand_i[n]) idx_o = IDX_W'(n);
        end
    end
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 5,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         bus_we_i,
    input  logic [ADDR_W-1:0]            bus_addr_i,
    input  logic [31:0]                  bus_wdata_i,
    output logic [31:0]                  bus_rdata_o,
    input  logic [NUM_SRC-1:0]           irq_i,
    input  logic                         claim_valid_i,
    input  logic [LVL_SEL_W-1:0]         claim_lvl_i,
    output logic [LVL_COUNT-1:0]         lvl_irq_o,
    output logic [LVL_COUNT*IDX_W-1:0]   lvl_vec_o,
    output logic                         wake_o,
    output logic                         claim_done_o,
    output logic                         claim_hit_o,
    output logic [IDX_W-1:0]             claim_vec_o
);
    typedef struct packed {
        logic [LVL_COUNT-1:0]            lvl;
        logic [LVL_COUNT-1:0][IDX_W-1:0] vec;
        logic                            wake;
        logic                            done;
        logic                            hit;
        logic [IDX_W-1:0]                cvec;
        logic [CNT_W-1:0]                spur;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_SRC*FIELD_W-1:0]          fld;
    logic [NUM_SRC-1:0]                  msk;
    logic [NUM_SRC-1:0]                  wen;
    logic [LVL_COUNT-1:0][NUM_SRC-1:0]   cand;
    logic [LVL_COUNT-1:0]                lvl_any;
    logic [LVL_COUNT-1:0][IDX_W-1:0]     lvl_idx;

    irq_router_cfg #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W)
    ) u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .raw_irq_i   (irq_i),
        .spur_cnt_i  (st_q.spur),
        .fld_o       (fld),
        .msk_o       (msk),
        .wen_o       (wen),
        .bus_rdata_o (bus_rdata_o)
    );

    // route every unmasked pending source onto the level its field names
    always_comb begin
        for (int l = 0; l < LVL_COUNT; l++) begin
            for (int n = 0; n < NUM_SRC; n++) begin
                cand[l][n] = irq_i[n] & msk[n] &
                             (fld[n*FIELD_W +: FIELD_W] == FIELD_W'(l));
            end
        end
    end

    for (genvar g = 0; g < LVL_COUNT; g++) begin : g_lvl
        irq_router_sel #(
            .NUM_SRC (NUM_SRC),
            .IDX_W   (IDX_W)
        ) u_sel (
            .cand_i (cand[g]),
            .any_o  (lvl_any[g]),
            .idx_o  (lvl_idx[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.lvl  = lvl_any;
        st_d.vec  = lvl_idx;
        st_d.wake = |(irq_i & wen);
        st_d.done = claim_valid_i;
        st_d.hit  = 1'b0;
        st_d.cvec = '0;
        if (claim_valid_i) begin
            for (int l = 0; l < LVL_COUNT; l++) begin
                if (claim_lvl_i == LVL_SEL_W'(l) && lvl_any[l]) begin
                    st_d.hit  = 1'b1;
                    st_d.cvec = lvl_idx[l];
                end
            end
            if (!st_d.hit) st_d.spur = st_q.spur + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_irq_o    = st_q.lvl;
    assign lvl_vec_o    = st_q.vec;
    assign wake_o       = st_q.wake;
    assign claim_done_o = st_q.done;
    assign claim_hit_o  = st_q.hit;
    assign claim_vec_o  = st_q.cvec;
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk #(
    parameter int NUM_SRC   = 64,
    parameter int IDX_W     = 6,
    parameter int LVL_COUNT = 7
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic [NUM_SRC-1:0]         irq_i,
    input logic                       claim_valid_i,
    input logic [2:0]                 claim_lvl_i,
    input logic [LVL_COUNT-1:0]       lvl_irq_o,
    input logic [LVL_COUNT*IDX_W-1:0] lvl_vec_o,
    input logic                       wake_o,
    input logic                       claim_done_o,
    input logic                       claim_hit_o,
    input logic [IDX_W-1:0]           claim_vec_o
);
    // R8
    claim_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        claim_valid_i |=> claim_done_o);

    // R8
    claim_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !claim_valid_i |=> !claim_done_o);

    // R9
    bad_level_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (claim_valid_i && claim_lvl_i == 3'd7) |=> (!claim_hit_o && claim_vec_o == '0));

    // R10
    wake_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i == '0) |=> !wake_o);

    // R5
    no_request_no_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_i == '0) |=> (lvl_irq_o == '0));

    for (genvar g = 0; g < LVL_COUNT; g++) begin : g_lv
        // R6
        idle_level_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !lvl_irq_o[g] |-> (lvl_vec_o[g*IDX_W +: IDX_W] == '0));
    end
endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC   (NUM_SRC),
    .IDX_W     ($clog2(NUM_SRC)),
    .LVL_COUNT (7)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .irq_i         (irq_i),
    .claim_valid_i (claim_valid_i),
    .claim_lvl_i   (claim_lvl_i),
    .lvl_irq_o     (lvl_irq_o),
    .lvl_vec_o     (lvl_vec_o),
    .wake_o        (wake_o),
    .claim_done_o  (claim_done_o),
    .claim_hit_o   (claim_hit_o),
    .claim_vec_o   (claim_vec_o)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] irq = '0;
    logic        cv = 1'b0;
    logic [2:0]  cl = '0;
    logic [6:0]  lvl;
    logic [41:0] vec;
    logic        wake, cdone, chit;
    logic [5:0]  cvec;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] asg [8];
    logic [31:0] msk [2];

    always #2.5 clk = ~clk;

    irq_router u_irq_router (
        .clk_i (clk), .rst_ni (rst_n), .bus_we_i (we), .bus_addr_i (addr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_i (irq),
        .claim_valid_i (cv), .claim_lvl_i (cl), .lvl_irq_o (lvl),
        .lvl_vec_o (vec), .wake_o (wake), .claim_done_o (cdone),
        .claim_hit_o (chit), .claim_vec_o (cvec)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = 5'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        addr = 5'(a);
        #1 d = rdata;
    endtask

    task automatic set_field(int n, int k);
        asg[n/8][(n%8)*4 +: 4] = 4'(k);
        wr(n/8, asg[n/8]);
    endtask

    task automatic set_mask(int n, bit v);
        msk[n/32][n%32] = v;
        wr(8 + n/32, msk[n/32]);
    endtask

    function automatic logic [5:0] vec_of(int l);
        return vec[l*6 +: 6];
    endfunction

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 lvl", 64'(lvl), 0);
        chk("R1 wake", 64'(wake), 0);
        chk("R1 done", 64'(cdone), 0);
        rd(0, d); chk("R1 assign0", 64'(d), 0);
        rd(9, d); chk("R1 mask1", 64'(d), 0);
        rd(14, d); chk("R1 counter", 64'(d), 0);
        irq = '1;
        settle(); settle();
        chk("R1 masked requests", 64'(lvl), 0);
        irq = '0;
        settle();
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(3, 32'h1234_5601); rd(3, d); chk("R2 assign3", 64'(d), 64'h1234_5601);
        wr(3, 32'h0);
        wr(9, 32'hA5A5_0000); rd(9, d); chk("R2 mask1", 64'(d), 64'hA5A5_0000);
        wr(9, 32'h0);
        wr(12, 32'h0000_F00F); rd(12, d); chk("R2 wake0", 64'(d), 64'h0000_F00F);
        wr(12, 32'h0);
        irq = 64'hDEAD_BEEF_0123_4567;
        rd(10, d); chk("R2 status0", 64'(d), 64'h0123_4567);
        rd(11, d); chk("R2 status1", 64'(d), 64'hDEAD_BEEF);
        irq = '0;
        settle();
    endtask

    task automatic t_route();
        set_field(13, 4); set_mask(13, 1'b1);
        set_field(40, 6); set_mask(40, 1'b1);
        @(negedge clk);
        irq = '0; irq[13] = 1'b1; irq[40] = 1'b1;
        settle();
        chk("R3 levels", 64'(lvl), 64'h50);
        chk("R3 vec4", 64'(vec_of(4)), 13);
        chk("R3 vec6", 64'(vec_of(6)), 40);
        // fields 7 and above go nowhere
        set_field(13, 9); settle();
        chk("R4 field9", 64'(lvl), 64'h40);
        set_field(13, 15); settle();
        chk("R4 field15", 64'(lvl), 64'h40);
        set_field(13, 4); settle();
        chk("R4 restore", 64'(lvl), 64'h50);
        // masking a source removes it
        set_mask(40, 1'b0); settle();
        chk("R5 mask cleared", 64'(lvl), 64'h10);
        chk("R5 vec6 idle", 64'(vec_of(6)), 0);
        set_mask(40, 1'b1);
        irq = '0;
        settle();
    endtask

    task automatic t_prio();
        set_field(5, 2); set_mask(5, 1'b1);
        set_field(13, 2); set_field(40, 2);
        @(negedge clk);
        irq = '0; irq[5] = 1'b1; irq[13] = 1'b1; irq[40] = 1'b1;
        settle();
        chk("R6 three on level", 64'(lvl), 64'h04);
        chk("R6 lowest 5", 64'(vec_of(2)), 5);
        @(negedge clk); irq[5] = 1'b0;
        settle();
        chk("R6 next 13", 64'(vec_of(2)), 13);
        @(negedge clk); irq[13] = 1'b0;
        settle();
        chk("R6 last 40", 64'(vec_of(2)), 40);
        @(negedge clk); irq = '0;
        settle();
    endtask

    task automatic t_timing();
        chk("R7 idle", 64'(lvl), 0);
        @(negedge clk);
        irq[40] = 1'b1;
        #1 chk("R7 not before edge", 64'(lvl), 0);
        @(negedge clk);
        chk("R7 after edge", 64'(lvl), 64'h04);
        chk("R7 vec after edge", 64'(vec_of(2)), 40);
    endtask

    task automatic t_claim();
        logic [31:0] d;
        @(negedge clk); cv = 1'b1; cl = 3'd2;
        @(negedge clk); cv = 1'b0;
        chk("R8 done", 64'(cdone), 1);
        chk("R8 hit", 64'(chit), 1);
        chk("R8 vec", 64'(cvec), 40);
        rd(14, d); chk("R8 no spurious", 64'(d), 0);
        chk("R8 done drops", 64'(cdone), 0);
        // empty level
        @(negedge clk); cv = 1'b1; cl = 3'd3;
        @(negedge clk); cv = 1'b0;
        chk("R9 empty done", 64'(cdone), 1);
        chk("R9 empty hit", 64'(chit), 0);
        chk("R9 empty vec", 64'(cvec), 0);
        rd(14, d); chk("R9 counter 1", 64'(d), 1);
        // out-of-range level number
        @(negedge clk); cv = 1'b1; cl = 3'd7;
        @(negedge clk); cv = 1'b0;
        chk("R9 level7 hit", 64'(chit), 0);
        rd(14, d); chk("R9 counter 2", 64'(d), 2);
        irq = '0;
        settle();
    endtask

    task automatic t_wake();
        set_mask(40, 1'b0);
        wr(13, 32'h0000_0100);
        @(negedge clk); irq = '0; irq[40] = 1'b1;
        settle();
        chk("R10 wake masked source", 64'(wake), 1);
        chk("R10 level stays low", 64'(lvl), 0);
        @(negedge clk); irq = '0; irq[41] = 1'b1;
        settle();
        chk("R10 non-enabled source", 64'(wake), 0);
        @(negedge clk); irq = '0;
        settle();
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(10, 32'hFFFF_FFFF);
        rd(10, d); chk("R11 status write ignored", 64'(d), 0);
        wr(14, 32'h5);
        rd(14, d); chk("R11 counter write ignored", 64'(d), 2);
        settle();
        chk("R11 no level change", 64'(lvl), 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) asg[i] = '0;
        for (int i = 0; i < 2; i++) msk[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_route();
        t_prio();
        t_timing();
        t_claim();
        t_wake();
        t_readonly();
        summary();
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end
endmodule